// File: doc/BRIEF.md
# Carry-Skip Adder

A purely combinational adder that forms `a_in + b_in + carry_in` with a carry-skip carry network. The default configuration is 16 bits wide and is cut into four 4-bit groups. Each bit first gets a generate term (both operand bits set) and a propagate term (operand bits differ). Inside a group the carry ripples from bit to bit. Each group also forms a group-propagate term, the AND of its propagates. When that term is set, the group's incoming carry goes straight to its outgoing carry and does not pass through the ripple chain.

Each sum bit is the bit's propagate XOR the carry that enters that bit. The carry out of the top group is the adder's carry-out. The group size is a parameter, and the width must be a whole multiple of it. The block sits in a datapath wherever a mid-speed adder is needed that costs little more than a ripple adder.

Top module: `csk_adder`

## Requirements
- R1: For every input, `{carry_out, sum_out}` equals `a_in + b_in + carry_in` taken as a WIDTH+1-bit unsigned sum.
- R2: `sum_out[0]` equals `a_in[0] XOR b_in[0] XOR carry_in`, because the carry into bit 0 is `carry_in`.
- R3: Within a group, the carry into bit i+1 is `gen(i) OR (prop(i) AND carry(i))`, where gen = a AND b and prop = a XOR b. When a group's bits are not all propagating, its carry-out is bit GROUP of the sum of its operand slices plus its carry-in.
- R4: When all GROUP bits of a group have `a_in` differing from `b_in`, the group's carry-out equals its carry-in.
- R5: Group k covers bits `[k*GROUP+GROUP-1 : k*GROUP]`. Group 0 takes `carry_in`, and each later group takes the carry-out of the group below it.
- R6: When `a_in XOR b_in` is all ones, `sum_out` is all ones and `carry_out` is 0 when `carry_in` is 0. When `carry_in` is 1, `sum_out` is all zeros and `carry_out` is 1.
- R7: `carry_out` is the carry-out of the top group. If the top bits of both operands are 1, `carry_out` is 1 regardless of every other input.
- R8: If the top bits of both operands are 0, `carry_out` is 0 regardless of every other input.
- R9: The adder gives the R1 result for any GROUP that divides WIDTH. An 8-bit adder built with GROUP = 2 and one built with GROUP = 4 both match for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the top group |

## Verification
The checker re-evaluates, whenever any input changes, three things: the whole arithmetic result, the skip rule for each group, and the ripple result of each non-skipping group against a separately computed slice sum. It also checks how the group carries chain together, from `carry_in` up to `carry_out`. The bench covers what a single evaluation cannot show. It walks exhaustive operand sweeps over two 8-bit configurations with different group sizes. It also drives directed vectors that force full-width skips with both carry-in values, long ripples that cross several groups, and top-bit generate and kill cases, and it adds random 16-bit operands.

// File: rtl/csk_pkg.sv
// Package: shared types for the carry-skip adder.
// Assumes: nothing beyond standard SystemVerilog packed structs.
package csk_pkg;

    // Per-bit carry behaviour: gen forces a carry, prop passes one on.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Number of groups for a given width and group size.
    function automatic int group_count(input int width, input int grp);
        return width / grp;
    endfunction

endpackage

// File: rtl/csk_gp_setup.sv
// Module: csk_gp_setup
// Forms the generate (a AND b) and propagate (a XOR b) pair for every bit.
// Assumes: purely combinational; WIDTH >= 1.
module csk_gp_setup
    import csk_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output gp_t  [WIDTH-1:0] gp
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Per-bit generate and propagate.
            assign gp[i].gen  = a[i] & b[i];
            assign gp[i].prop = a[i] ^ b[i];
        end
    endgenerate

endmodule

// File: rtl/csk_group.sv
// Module: csk_group
// One carry-skip group: a ripple chain over GROUP bits plus a bypass that
// forwards the group carry-in to the carry-out when every bit propagates.
// Assumes: GROUP >= 1; purely combinational.
module csk_group
    import csk_pkg::*;
#(
    parameter int GROUP = 4
) (
    input  gp_t  [GROUP-1:0] gp,
    input  logic             c_in,
    output logic [GROUP-1:0] bit_carry,
    output logic             c_out
);

    logic [GROUP:0]   chain;
    logic [GROUP-1:0] prop_vec;
    logic             block_prop;

    assign chain[0] = c_in;

    genvar i;
    generate
        for (i = 0; i < GROUP; i++) begin : g_ripple
            // Carry recurrence: generate, or propagate the incoming carry.
            assign chain[i+1]   = gp[i].gen | (gp[i].prop & chain[i]);
            assign prop_vec[i]  = gp[i].prop;
            assign bit_carry[i] = chain[i];
        end
    endgenerate

    // Group propagate: every bit passes its carry on.
    assign block_prop = &prop_vec;

    // Skip multiplexer: bypass the ripple chain when the group propagates.
    always_comb begin
        c_out = block_prop ? c_in : chain[GROUP];
    end

endmodule

// File: rtl/csk_sum.sv
// Module: csk_sum
// Sum formation: each sum bit is its propagate XOR its incoming carry.
// Assumes: carry[i] is the carry into bit i.
module csk_sum
    import csk_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  gp_t  [WIDTH-1:0] gp,
    input  logic [WIDTH-1:0] carry,
    output logic [WIDTH-1:0] sum
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_sum
            // Sum bit from propagate and carry.
            assign sum[i] = gp[i].prop ^ carry[i];
        end
    endgenerate

endmodule

// File: rtl/csk_adder.sv
// Module: csk_adder (top)
// Carry-skip adder: WIDTH bits split into WIDTH/GROUP ripple groups, each with
// a group-propagate bypass. The carry-out is the skip output of the top group.
// Assumes: WIDTH is a whole multiple of GROUP; purely combinational, no reset.
module csk_adder
    import csk_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NGROUPS = group_count(WIDTH, GROUP);

    gp_t  [WIDTH-1:0]   gp;
    logic [WIDTH-1:0]   bit_carry;
    logic [NGROUPS:0]   grp_c;

    generate
        if ((WIDTH % GROUP) != 0) begin : g_bad_cfg
            $error("csk_adder: WIDTH must be a multiple of GROUP");
        end
    endgenerate

    // Setup stage: per-bit generate and propagate.
    csk_gp_setup #(.WIDTH(WIDTH)) u_setup (
        .a  (a_in),
        .b  (b_in),
        .gp (gp)
    );

    // The carry into group 0 is the adder carry-in.
    assign grp_c[0] = carry_in;

    genvar k;
    generate
        for (k = 0; k < NGROUPS; k++) begin : g_grp
            // One skip group per GROUP-bit slice, chained by group carries.
            csk_group #(.GROUP(GROUP)) u_group (
                .gp        (gp[k*GROUP +: GROUP]),
                .c_in      (grp_c[k]),
                .bit_carry (bit_carry[k*GROUP +: GROUP]),
                .c_out     (grp_c[k+1])
            );
        end
    endgenerate

    // Sum formation from propagate and per-bit carry.
    csk_sum #(.WIDTH(WIDTH)) u_sum (
        .gp    (gp),
        .carry (bit_carry),
        .sum   (sum_out)
    );

    // The final carry-out is the top group's skip output.
    assign carry_out = grp_c[NGROUPS];

endmodule

// File: rtl/csk_adder_chk.sv
// Module: csk_adder_chk
// Checker for csk_adder, attached by bind. Re-evaluates the arithmetic, the
// per-group skip rule and the group carry chain whenever inputs change.
// Assumes: bound to csk_adder with matching WIDTH and GROUP.
module csk_adder_chk #(
    parameter int WIDTH = 16,
    parameter int GROUP = 4
) (
    input logic [WIDTH-1:0]       a_in,
    input logic [WIDTH-1:0]       b_in,
    input logic                   carry_in,
    input logic [WIDTH-1:0]       sum_out,
    input logic                   carry_out,
    input logic [WIDTH/GROUP:0]   grp_c
);

    localparam int NG = WIDTH / GROUP;

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, carry_in};

    // Whole-result and chain-end checks.
    always_comb begin
        assert_total_R1: assert ({carry_out, sum_out} == ref_total)
            else $error("R1 total mismatch");
        assert_bit0_R2: assert (sum_out[0] == (a_in[0] ^ b_in[0] ^ carry_in))
            else $error("R2 bit0 mismatch");
        assert_chain_ends_R5: assert (grp_c[0] == carry_in && grp_c[NG] == carry_out)
            else $error("R5 chain ends mismatch");
        if (&(a_in ^ b_in)) begin
            assert_full_skip_R6: assert (carry_out == carry_in && sum_out == {WIDTH{~carry_in}})
                else $error("R6 full skip mismatch");
        end
        if (a_in[WIDTH-1] && b_in[WIDTH-1]) begin
            assert_top_gen_R7: assert (carry_out) else $error("R7 top generate");
        end
        if (!a_in[WIDTH-1] && !b_in[WIDTH-1]) begin
            assert_top_kill_R8: assert (!carry_out) else $error("R8 top kill");
        end
    end

    genvar k;
    generate
        for (k = 0; k < NG; k++) begin : g_chk
            logic [GROUP-1:0] sl_a;
            logic [GROUP-1:0] sl_b;
            logic [GROUP:0]   sl_sum;
            assign sl_a   = a_in[k*GROUP +: GROUP];
            assign sl_b   = b_in[k*GROUP +: GROUP];
            assign sl_sum = {1'b0, sl_a} + {1'b0, sl_b} + {{GROUP{1'b0}}, grp_c[k]};
            // Per-group skip and ripple checks.
            always_comb begin
                if (&(sl_a ^ sl_b)) begin
                    assert_skip_R4: assert (grp_c[k+1] == grp_c[k])
                        else $error("R4 skip mismatch");
                end else begin
                    assert_ripple_R3: assert (grp_c[k+1] == sl_sum[GROUP])
                        else $error("R3 ripple mismatch");
                end
            end
        end
    endgenerate

endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .GROUP(GROUP)) u_chk (
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .grp_c     (grp_c)
);

// File: tb/csk_adder_tb.sv
// Bench for csk_adder: directed and random 16-bit vectors on the default
// configuration, plus exhaustive sweeps of two 8-bit configurations.
module csk_adder_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] a16, b16;
    logic        c16;
    logic [15:0] s16;
    logic        co16;

    logic [7:0]  a8, b8;
    logic        c8;
    logic [7:0]  s8g2, s8g4;
    logic        co8g2, co8g4;

    csk_adder #(.WIDTH(16), .GROUP(4)) u_dut (
        .a_in(a16), .b_in(b16), .carry_in(c16), .sum_out(s16), .carry_out(co16)
    );
    csk_adder #(.WIDTH(8), .GROUP(2)) u_dut_n8g2 (
        .a_in(a8), .b_in(b8), .carry_in(c8), .sum_out(s8g2), .carry_out(co8g2)
    );
    csk_adder #(.WIDTH(8), .GROUP(4)) u_dut_n8g4 (
        .a_in(a8), .b_in(b8), .carry_in(c8), .sum_out(s8g4), .carry_out(co8g4)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one 16-bit vector, let it settle, compare against arithmetic.
    task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] exp;
        a16 = a; b16 = b; c16 = c;
        #1;
        exp = {1'b0, a} + {1'b0, b} + {16'd0, c};
        check(req, {co16, s16}, exp);
    endtask

    initial begin
        a16 = '0; b16 = '0; c16 = 1'b0;
        a8 = '0; b8 = '0; c8 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1: all-zero inputs give zero sum and no carry
        run16("R1 zero", 16'h0000, 16'h0000, 1'b0);
        // R2: bit 0 sum from carry_in
        run16("R2 bit0", 16'h0001, 16'h0000, 1'b1);
        // R3: ripple within group 0
        run16("R3 ripple", 16'h0007, 16'h0001, 1'b0);
        // R4: group 1 fully propagates carry generated in group 0
        run16("R4 skip", 16'h005F, 16'h00A1, 1'b0);
        // R5: carry crosses three groups
        run16("R5 chain", 16'h0FFF, 16'h0001, 1'b0);
        // R6: full-width skip, both carry-in values
        run16("R6 skip cin0", 16'hA5C3, 16'h5A3C, 1'b0);
        run16("R6 skip cin1", 16'hA5C3, 16'h5A3C, 1'b1);
        run16("R6 skip ones cin1", 16'hFFFF, 16'h0000, 1'b1);
        // R7: top generate
        run16("R7 top gen", 16'h8000, 16'h8000, 1'b0);
        run16("R7 top gen low ones", 16'hFFFF, 16'h8000, 1'b1);
        // R8: top kill
        run16("R8 top kill", 16'h7FFF, 16'h7FFF, 1'b1);
        run16("R8 top kill b", 16'h7FFF, 16'h0001, 1'b1);

        // R1: random operands
        for (int i = 0; i < 4000; i++) begin
            run16("R1 random", 16'($urandom), 16'($urandom), 1'($urandom));
        end

        // R9: exhaustive 8-bit sweeps, group sizes 2 and 4
        for (int ci = 0; ci < 2; ci++) begin
            for (int ia = 0; ia < 256; ia++) begin
                for (int ib = 0; ib < 256; ib++) begin
                    logic [8:0] exp8;
                    a8 = 8'(ia); b8 = 8'(ib); c8 = 1'(ci);
                    #1;
                    exp8 = 9'(ia + ib + ci);
                    check("R9 group2", {8'd0, co8g2, s8g2}, {8'd0, exp8});
                    check("R9 group4", {8'd0, co8g4, s8g4}, {8'd0, exp8});
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule